// File: doc/BRIEF.md
# Write-Only Port Shadow Readback

This block keeps a copy of the last byte the CPU wrote to each of four write-only control ports: the main memory paging port, the extended paging port, the high paging port and the border/speaker port. Software that has lost track of the machine state can read any of these copies back through a small group of read-only alias I/O addresses. Two address lines pick which copy is returned.

The CPU side is a Z80-style I/O bus, already synchronised to the system clock: a 16-bit address, an 8-bit write data bus and active-high request, read and write strobes. A write is captured once per bus access, on the first clock edge where request and write are both seen. Alias reads are answered on a registered read data bus with a matching drive enable. The four copies are also presented directly as outputs for neighbouring logic.

Top module: `port_shadow_readback`

## Requirements
- R1: While `rst` is high, all four shadow outputs, `rd_data` and `rd_drive` are zero in the cycle after each clock edge.
- R2: A write with A15=0 and A1=0 that does not match the R3 pattern stores the write data in `shd_main`.
- R3: A write with A15..A12=0001 and A1=0 stores the data in `shd_ext` and leaves `shd_main` unchanged.
- R4: A write with A15..A12=1101 and A1=0 stores the data in `shd_high`.
- R5: A write with A0=0 stores the data in `shd_border`, alongside any other shadow that the same address selects.
- R6: Each write access is captured only once, using the data present on the first clock edge where `io_req` and `io_wr` are both high. Later data changes while the strobe stays high are ignored.
- R7: A read is an alias read when A15=1, A14=0, A1=0 and A0=1. {A9,A5} selects the copy: 00 gives `shd_high`, 01 gives `shd_ext`, 10 gives `shd_border` and 11 gives `shd_main`. The copy appears on `rd_data`, with `rd_drive` high, in the cycle after the edge where the read was sampled.
- R8: With no request, no read strobe, or an address that is not an alias, `rd_drive` is low and `rd_data` is zero in the following cycle.
- R9: An alias read never changes a shadow. A write strobe that arrives while `io_rd` is also high is ignored.
- R10: A shadow keeps its value when no qualifying write is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | I/O request strobe, active high |
| io_rd | input | 1 | Read strobe, active high |
| io_wr | input | 1 | Write strobe, active high |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data from CPU |
| rd_data | output | 8 | Registered alias read data; zero when not driving |
| rd_drive | output | 1 | Registered enable for driving the CPU data bus |
| shd_main | output | 8 | Copy of the main paging port |
| shd_ext | output | 8 | Copy of the extended paging port |
| shd_high | output | 8 | Copy of the high paging port |
| shd_border | output | 8 | Copy of the border/speaker port |

## Verification
The assertions assume the strobes are already synchronous to `clk` and that address and data hold steady on the edge where an access starts. They also assume read and write accesses are separated by at least one cycle with `io_req` low, so that each access produces its own strobe edge. The bench changes every input only on the falling clock edge, lowers all strobes for an idle cycle between accesses, and combines read and write only in the one scenario built to show that this combination is ignored.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int NUM_SHADOW = 4;
  localparam int SEL_W      = $clog2(NUM_SHADOW);

  // Index order equals {A9,A5} of the alias read decode
  typedef enum logic [SEL_W-1:0] {
    SH_HIGH   = 2'd0,
    SH_EXT    = 2'd1,
    SH_BORDER = 2'd2,
    SH_MAIN   = 2'd3
  } shadow_id_t;
endpackage

// File: rtl/psr_write_decode.sv
module psr_write_decode
  import psr_pkg::*;
(
  input  logic [3:0]            addr_top,   // A15..A12
  input  logic                  addr_a1,
  input  logic                  addr_a0,
  output logic [NUM_SHADOW-1:0] hit
);
  localparam logic [3:0] EXT_NIBBLE  = 4'b0001;
  localparam logic [3:0] HIGH_NIBBLE = 4'b1101;

  logic ext_match;
  logic high_match;
  logic main_match;

  always_comb begin
    ext_match  = (addr_top == EXT_NIBBLE)  && !addr_a1;
    high_match = (addr_top == HIGH_NIBBLE) && !addr_a1;
    // extended port pattern takes precedence over the main port pattern
    main_match = !addr_top[3] && !addr_a1 && !ext_match;
    hit            = '0;
    hit[SH_MAIN]   = main_match;
    hit[SH_EXT]    = ext_match;
    hit[SH_HIGH]   = high_match;
    hit[SH_BORDER] = !addr_a0;
  end
endmodule

// File: rtl/psr_alias_decode.sv
module psr_alias_decode
  import psr_pkg::*;
(
  input  logic             a15,
  input  logic             a14,
  input  logic             a9,
  input  logic             a5,
  input  logic             a1,
  input  logic             a0,
  output logic             is_alias,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    is_alias = a15 && !a14 && !a1 && a0;
    sel      = {a9, a5};
  end
endmodule

// File: rtl/psr_shadow_bank.sv
module psr_shadow_bank
  import psr_pkg::*;
#(
  parameter int N = NUM_SHADOW,
  parameter int W = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [N-1:0]     hit,
  input  logic [W-1:0]     wdata,
  output logic [N-1:0][W-1:0] regs
);
  for (genvar i = 0; i < N; i++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (capture && hit[i])
        regs[i] <= wdata;
    end
  end
endmodule

// File: rtl/port_shadow_readback.sv
module port_shadow_readback
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic [DATA_W-1:0] shd_main,
  output logic [DATA_W-1:0] shd_ext,
  output logic [DATA_W-1:0] shd_high,
  output logic [DATA_W-1:0] shd_border
);
  logic                           wr_now;
  logic                           wr_prev;
  logic                           wr_fire;
  logic [NUM_SHADOW-1:0]          wr_hit;
  logic [NUM_SHADOW-1:0][DATA_W-1:0] bank;
  logic                           alias_hit;
  logic [SEL_W-1:0]               alias_sel;
  logic                           rd_now;
  logic                           unused_addr_bits;

  assign unused_addr_bits = ^{io_addr[11:10], io_addr[8:6], io_addr[4:2]};

  // one capture per access: fire on the rising edge of the write strobe
  assign wr_now  = io_req && io_wr && !io_rd;
  assign wr_fire = wr_now && !wr_prev;

  always_ff @(posedge clk) begin
    if (rst) wr_prev <= 1'b0;
    else     wr_prev <= wr_now;
  end

  psr_write_decode u_wdec (
    .addr_top (io_addr[15:12]),
    .addr_a1  (io_addr[1]),
    .addr_a0  (io_addr[0]),
    .hit      (wr_hit)
  );

  psr_shadow_bank #(.N(NUM_SHADOW), .W(DATA_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .capture (wr_fire),
    .hit     (wr_hit),
    .wdata   (io_wdata),
    .regs    (bank)
  );

  psr_alias_decode u_adec (
    .a15      (io_addr[15]),
    .a14      (io_addr[14]),
    .a9       (io_addr[9]),
    .a5       (io_addr[5]),
    .a1       (io_addr[1]),
    .a0       (io_addr[0]),
    .is_alias (alias_hit),
    .sel      (alias_sel)
  );

  assign rd_now = io_req && io_rd && alias_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_drive <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_drive <= rd_now;
      rd_data  <= rd_now ? bank[alias_sel] : '0;
    end
  end

  assign shd_main   = bank[SH_MAIN];
  assign shd_ext    = bank[SH_EXT];
  assign shd_high   = bank[SH_HIGH];
  assign shd_border = bank[SH_BORDER];
endmodule

// File: rtl/psr_checker.sv
module psr_checker
  import psr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              io_req,
  input logic              io_rd,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_addr,
  input logic [DATA_W-1:0] io_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_drive,
  input logic [DATA_W-1:0] shd_main,
  input logic [DATA_W-1:0] shd_ext,
  input logic [DATA_W-1:0] shd_high,
  input logic [DATA_W-1:0] shd_border
);
  logic [4*DATA_W-1:0] all_shd;
  logic                wr_cyc;
  logic                alias_rd;
  assign all_shd  = {shd_main, shd_ext, shd_high, shd_border};
  assign wr_cyc   = io_req && io_wr && !io_rd;
  assign alias_rd = io_req && io_rd && io_addr[15] && !io_addr[14]
                    && !io_addr[1] && io_addr[0];

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (all_shd == '0 && !rd_drive && rd_data == '0)); // R1

  AST_BORDER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (wr_cyc && !$past(wr_cyc) && !io_addr[0]) |=> shd_border == $past(io_wdata)); // R5

  AST_HIGH_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (wr_cyc && !$past(wr_cyc) && io_addr[15:12] == 4'b1101 && !io_addr[1])
    |=> shd_high == $past(io_wdata)); // R4

  AST_EXT_SPARES_MAIN: assert property (@(posedge clk) disable iff (rst)
    (io_addr[15:12] == 4'b0001) |=> $stable(shd_main)); // R3

  AST_DRIVE_NEEDS_ALIAS: assert property (@(posedge clk) disable iff (rst)
    !alias_rd |=> !rd_drive); // R8

  AST_RELEASED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_drive |-> rd_data == '0); // R8

  AST_ALIAS_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    alias_rd |=> $stable(all_shd)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wr_cyc |=> $stable(all_shd)); // R10

  AST_ONCE_PER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (wr_cyc && $past(wr_cyc)) |=> $stable(all_shd)); // R6
endmodule

bind port_shadow_readback psr_checker chk_i (
  .clk        (clk),
  .rst        (rst),
  .io_req     (io_req),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .io_addr    (io_addr),
  .io_wdata   (io_wdata),
  .rd_data    (rd_data),
  .rd_drive   (rd_drive),
  .shd_main   (shd_main),
  .shd_ext    (shd_ext),
  .shd_high   (shd_high),
  .shd_border (shd_border)
);

// File: tb/port_shadow_readback_tb_top.sv
`timescale 1ns/1ps
module port_shadow_readback_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req = 1'b0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  rd_data;
  logic        rd_drive;
  logic [7:0]  shd_main, shd_ext, shd_high, shd_border;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // expected copies: main, ext, high, border
  logic [7:0] e_main = 8'h00, e_ext = 8'h00, e_high = 8'h00, e_border = 8'h00;

  always #5 clk = ~clk;

  port_shadow_readback dut_i (
    .clk(clk), .rst(rst), .io_req(io_req), .io_rd(io_rd), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .rd_data(rd_data),
    .rd_drive(rd_drive), .shd_main(shd_main), .shd_ext(shd_ext),
    .shd_high(shd_high), .shd_border(shd_border)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic check_shadows(input string req);
    check(req, "shd_main",   shd_main,   e_main);
    check(req, "shd_ext",    shd_ext,    e_ext);
    check(req, "shd_high",   shd_high,   e_high);
    check(req, "shd_border", shd_border, e_border);
  endtask

  task automatic idle();
    @(negedge clk);
    io_req = 1'b0; io_rd = 1'b0; io_wr = 1'b0;
  endtask

  // one write access held for 'hold' cycles; outputs checked one edge later
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_req = 1'b1; io_wr = 1'b1;
    for (int i = 0; i < hold; i++) @(negedge clk);
    io_req = 1'b0; io_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d, output logic en);
    @(negedge clk);
    io_addr = a; io_req = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    d = rd_data; en = rd_drive;
    io_req = 1'b0; io_rd = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "rd_data", rd_data, 8'h00);
    check("R1", "rd_drive", {7'd0, rd_drive}, 8'h00);
    check_shadows("R1");
  endtask

  task automatic t_write_main();
    bus_write(16'h7FFD, 8'h17, 1); e_main = 8'h17;
    check_shadows("R2");
  endtask

  task automatic t_write_ext();
    bus_write(16'h1FFD, 8'h04, 1); e_ext = 8'h04;
    check_shadows("R3");
  endtask

  task automatic t_write_high();
    bus_write(16'hDFFD, 8'h3C, 1); e_high = 8'h3C;
    check_shadows("R4");
  endtask

  task automatic t_write_border();
    bus_write(16'h00FE, 8'h05, 1); e_border = 8'h05;
    check_shadows("R5");
    // A1=0 and A0=0 selects main and border together
    bus_write(16'h7FFC, 8'h92, 1); e_main = 8'h92; e_border = 8'h92;
    check_shadows("R5");
  endtask

  task automatic t_once_per_access();
    @(negedge clk);
    io_addr = 16'hDFFD; io_wdata = 8'hA1; io_req = 1'b1; io_wr = 1'b1;
    @(negedge clk);
    io_wdata = 8'h5E;
    @(negedge clk);
    @(negedge clk);
    io_req = 1'b0; io_wr = 1'b0;
    e_high = 8'hA1;
    check_shadows("R6");
  endtask

  task automatic t_alias_reads();
    logic [7:0] d; logic en;
    bus_read(16'hBDDD, d, en);
    check("R7", "high via BDDD", d, e_high);
    check("R7", "drive BDDD", {7'd0, en}, 8'h01);
    bus_read(16'hBDFD, d, en);
    check("R7", "ext via BDFD", d, e_ext);
    bus_read(16'hBFDD, d, en);
    check("R7", "border via BFDD", d, e_border);
    bus_read(16'hBFFD, d, en);
    check("R7", "main via BFFD", d, e_main);
    check("R7", "drive BFFD", {7'd0, en}, 8'h01);
    // don't-care bits cleared: A15=1,A0=1,A9=0,A5=0 gives the high copy
    bus_read(16'h8001, d, en);
    check("R7", "high via 8001", d, e_high);
    bus_read(16'h8221, d, en);
    check("R7", "main via 8221", d, e_main);
    check_shadows("R9");
  endtask

  task automatic t_release();
    logic [7:0] d; logic en;
    bus_read(16'hFFFD, d, en);   // A14=1
    check("R8", "drive A14 set", {7'd0, en}, 8'h00);
    check("R8", "data A14 set", d, 8'h00);
    bus_read(16'hBFFF, d, en);   // A1=1
    check("R8", "drive A1 set", {7'd0, en}, 8'h00);
    bus_read(16'h3FFD, d, en);   // A15=0
    check("R8", "drive A15 clear", {7'd0, en}, 8'h00);
    @(negedge clk);
    io_addr = 16'hBFFD; io_rd = 1'b1; io_req = 1'b0;
    @(negedge clk);
    check("R8", "drive no request", {7'd0, rd_drive}, 8'h00);
    check("R8", "data no request", rd_data, 8'h00);
    io_rd = 1'b0;
    @(negedge clk);
    check("R8", "drive after read", {7'd0, rd_drive}, 8'h00);
  endtask

  task automatic t_no_change();
    @(negedge clk);
    io_addr = 16'h7FFD; io_wdata = 8'hEE; io_req = 1'b1; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_req = 1'b0; io_wr = 1'b0; io_rd = 1'b0;
    check_shadows("R9");
    repeat (5) @(negedge clk);
    check_shadows("R10");
    bus_write(16'hBFFD, 8'h66, 1);  // alias address is not a write target
    check_shadows("R9");
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    e_main = 8'h00; e_ext = 8'h00; e_high = 8'h00; e_border = 8'h00;
    check_shadows("R1");
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    idle();
    t_write_main();
    t_write_ext();
    t_write_high();
    t_write_border();
    t_once_per_access();
    t_alias_reads();
    t_release();
    t_no_change();
    t_reset_again();
    idle();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule